// File: doc/BRIEF.md
# Linked-Tag DMA Chain Walker

This block follows a linked list of 64-bit DMA tags held in memory. Each tag says how many 16-byte quadwords of payload to move, where that payload lies, and where the next tag lies. The walker fetches a tag through a simple read port and decodes it. It hands the payload to a memory-side engine as an address and quadword-count burst request, then moves to the next tag. A small hardware return-address stack lets a chain call a sub-list and come back from it. The walk stops at a terminating tag, or on an error.

Software, or a parent controller, starts a walk by pulsing `start_i` with the address of the first tag. `busy_o` stays high until the chain ends. At the end a one-cycle `done_o` pulse is given. If a tag asks for it and `tie_i` is set, a one-cycle `irq_o` pulse is given after that tag's payload. `tag_hi_o` always shows the upper half of the command word of the most recent tag read.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the following are all 0: `busy_o`, `tag_req_o`, `burst_req_o`, `done_o`, `irq_o`, `err_o`, `asp_o` and `tag_hi_o`.
- R2: While idle, a `start_i` pulse with an aligned `start_tadr_i` does three things: it raises `busy_o`, it empties the stack, and it clears `err_o`. The first tag is then requested from that address. A `start_i` pulse while `busy_o` is high has no effect on the walk.
- R3: Tag layout is fixed. Bits 63:32 hold the address. Bit 31 is the interrupt request. Bits 30:28 hold the kind. Bits 15:0 hold the quadword count. `tag_hi_o` holds bits 31:16 of the last tag accepted.
- R4: Three kinds place the payload right after the tag. For kind 1 (count), the next tag follows the payload. For kind 2 (jump), the next tag is at the tag's address. For kind 7 (stop), the chain ends.
- R5: Three kinds place the payload at the tag's address. For kinds 3 and 4 (fetch-by-reference), the next tag follows the tag. For kind 0 (reference-and-stop), the chain ends.
- R6: Kind 5 (subroutine) places its payload after the tag. It pushes the address that follows its payload and continues at the tag's address. `asp_o` shows the number of entries pushed: 0, 1 or 2.
- R7: Kind 6 (return) places its payload after the tag. With `asp_o` above 0, it continues at the most recently pushed address and pops it. With `asp_o` at 0, the chain ends after its payload.
- R8: A subroutine tag seen while 2 entries are pushed does three things: it sets `err_o`, it drops `busy_o` without a `done_o` pulse, and it issues no burst.
- R9: A tag with count 0 issues no burst, and the walk goes straight on to the next step.
- R10: `irq_o` pulses for one cycle after a tag's payload completes, but only if that tag had bit 31 set and `tie_i` was 1 when the tag was accepted.
- R11: When the chain ends, `busy_o` falls and `done_o` pulses for exactly one cycle.
- R12: Some kinds use the tag's address field: 0, 2, 3, 4 and 5. If such a tag has any of the low 4 bits of that field set, the walk stops with `err_o` set. A start address with any low 4 bits set sets `err_o` and the walker stays idle.
- R13: `burst_req_o`, `burst_addr_o` and `burst_qwc_o` hold steady until `burst_ack_i` is seen. `tag_req_o` and `burst_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| start_tadr_i | input | AW | Byte address of the first tag |
| tie_i | input | 1 | Tag interrupt enable |
| busy_o | output | 1 | Walk in progress |
| tag_req_o | output | 1 | Tag read request |
| tag_addr_o | output | AW | Tag read address |
| tag_vld_i | input | 1 | Tag read data valid (accepts the request) |
| tag_data_i | input | 64 | Tag read data |
| burst_req_o | output | 1 | Payload burst request |
| burst_addr_o | output | AW | Payload byte address |
| burst_qwc_o | output | 16 | Payload length in quadwords |
| burst_ack_i | input | 1 | Burst accepted and complete |
| tag_hi_o | output | 16 | Bits 31:16 of the last tag read |
| asp_o | output | SPW | Return stack entries in use |
| irq_o | output | 1 | Tag interrupt pulse |
| done_o | output | 1 | Chain end pulse |
| err_o | output | 1 | Chain error flag |

## Verification
The walker is driven with several kinds of chain:
- A plain count-then-stop chain, which tells apart the two payload placements that follow the tag.
- A jump, reference and zero-length mix, which tells apart addressed payloads from inline ones, and a skipped burst from an issued one.
- A nested subroutine and return chain, which tells the stack order and the empty-return end case apart.
- A third-level call and a misaligned address, which both separate an error stop from a normal end.

Tag and burst responders run with zero and with several cycles of latency, to expose hold and handshake faults. A second start is injected mid-walk, and the interrupt chain is run with the enable both on and off.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int TAG_W    = 64;
  localparam int ADDR_LSB = 32;
  localparam int IRQ_BIT  = 31;
  localparam int KIND_LSB = 28;
  localparam int HI_LSB   = 16;
  localparam int QWC_W    = 16;
  localparam int QW_SHIFT = 4;

  typedef enum logic [2:0] {
    K_REFSTOP = 3'd0,
    K_COUNT   = 3'd1,
    K_JUMP    = 3'd2,
    K_REF     = 3'd3,
    K_REFS    = 3'd4,
    K_CALL    = 3'd5,
    K_RET     = 3'd6,
    K_STOP    = 3'd7
  } tag_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_BURST = 2'd2
  } walk_state_e;
endpackage

// File: rtl/dma_addr_stack.sv
module dma_addr_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 2,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o,
  output logic [PW-1:0] ptr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] ent_q [DEPTH];
  logic [PW-1:0] ptr_q;

  assign full_o  = (ptr_q == PW'(DEPTH));
  assign empty_o = (ptr_q == '0);
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++)
        if (ptr_q == PW'(i)) ent_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (clr_i)              ptr_q <= '0;
    else if (push_i && !full_o)  ptr_q <= ptr_q + PW'(1);
    else if (pop_i && !empty_o)  ptr_q <= ptr_q - PW'(1);
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr_q == PW'(i + 1)) top_o = ent_q[i];
  end
endmodule

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [AW-1:0]    tadr_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  logic [AW-1:0]    top_i,
  output logic [AW-1:0]    pay_addr_o,
  output logic [QWC_W-1:0] qwc_o,
  output logic [AW-1:0]    next_o,
  output logic [AW-1:0]    link_o,
  output logic             last_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             irq_o,
  output logic             err_o
);
  tag_kind_e     kind;
  logic [AW-1:0] taddr, after_tag, after_pay;
  logic          uses_addr;
  logic          unused_mid;

  assign kind       = tag_kind_e'(tag_i[KIND_LSB +: 3]);
  assign taddr      = tag_i[ADDR_LSB +: AW];
  assign qwc_o      = tag_i[QWC_W-1:0];
  assign irq_o      = tag_i[IRQ_BIT];
  assign after_tag  = tadr_i + AW'(1 << QW_SHIFT);
  assign after_pay  = after_tag + (AW'(qwc_o) << QW_SHIFT);
  assign link_o     = after_pay;
  assign unused_mid = ^tag_i[KIND_LSB-1:QWC_W];

  always_comb begin
    pay_addr_o = after_tag;
    next_o     = after_pay;
    last_o     = 1'b0;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    uses_addr  = 1'b0;
    unique case (kind)
      K_REFSTOP: begin pay_addr_o = taddr; last_o = 1'b1; uses_addr = 1'b1; end
      K_COUNT:   ;
      K_JUMP:    begin next_o = taddr; uses_addr = 1'b1; end
      K_REF,
      K_REFS:    begin pay_addr_o = taddr; next_o = after_tag; uses_addr = 1'b1; end
      K_CALL:    begin next_o = taddr; push_o = 1'b1; uses_addr = 1'b1; end
      K_RET: begin
        if (empty_i) last_o = 1'b1;
        else begin next_o = top_i; pop_o = 1'b1; end
      end
      K_STOP:    last_o = 1'b1;
      default:   ;
    endcase
  end

  assign err_o = (uses_addr && (taddr[QW_SHIFT-1:0] != '0)) ||
                 ((kind == K_CALL) && full_i);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int  AW    = 32,
  parameter int  DEPTH = 2,
  localparam int SPW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    start_tadr_i,
  input  logic             tie_i,
  output logic             busy_o,
  output logic             tag_req_o,
  output logic [AW-1:0]    tag_addr_o,
  input  logic             tag_vld_i,
  input  logic [TAG_W-1:0] tag_data_i,
  output logic             burst_req_o,
  output logic [AW-1:0]    burst_addr_o,
  output logic [QWC_W-1:0] burst_qwc_o,
  input  logic             burst_ack_i,
  output logic [15:0]      tag_hi_o,
  output logic [SPW-1:0]   asp_o,
  output logic             irq_o,
  output logic             done_o,
  output logic             err_o
);
  walk_state_e      state_q;
  logic [AW-1:0]    tadr_q, madr_q, nxt_q;
  logic [QWC_W-1:0] qwc_q;
  logic             last_q, irqp_q, err_q, done_q, irq_q;
  logic [15:0]      hi_q;

  logic [AW-1:0]    d_pay, d_next, d_link, stk_top;
  logic [QWC_W-1:0] d_qwc;
  logic             d_last, d_push, d_pop, d_irq, d_err;
  logic             stk_full, stk_empty;
  logic             take, go, start_ok;

  assign take     = (state_q == S_FETCH) && tag_vld_i;
  assign go       = (state_q == S_IDLE) && start_i;
  assign start_ok = (start_tadr_i[QW_SHIFT-1:0] == '0);

  dma_tag_decode #(.AW(AW)) u_dec (
    .tag_i      (tag_data_i),
    .tadr_i     (tadr_q),
    .full_i     (stk_full),
    .empty_i    (stk_empty),
    .top_i      (stk_top),
    .pay_addr_o (d_pay),
    .qwc_o      (d_qwc),
    .next_o     (d_next),
    .link_o     (d_link),
    .last_o     (d_last),
    .push_o     (d_push),
    .pop_o      (d_pop),
    .irq_o      (d_irq),
    .err_o      (d_err)
  );

  dma_addr_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (go && start_ok),
    .push_i  (take && d_push && !d_err),
    .pop_i   (take && d_pop && !d_err),
    .din_i   (d_link),
    .top_o   (stk_top),
    .ptr_o   (asp_o),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tadr_q  <= '0;
      madr_q  <= '0;
      nxt_q   <= '0;
      qwc_q   <= '0;
      last_q  <= 1'b0;
      irqp_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      hi_q    <= '0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (!start_ok) err_q <= 1'b1;
          else begin
            err_q   <= 1'b0;
            tadr_q  <= start_tadr_i;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: if (tag_vld_i) begin
          hi_q <= tag_data_i[HI_LSB +: 16];
          if (d_err) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (d_qwc != '0) begin
            madr_q  <= d_pay;
            qwc_q   <= d_qwc;
            nxt_q   <= d_next;
            last_q  <= d_last;
            irqp_q  <= d_irq && tie_i;
            state_q <= S_BURST;
          end else begin
            // empty payload: step completes on the tag itself
            tadr_q  <= d_next;
            done_q  <= d_last;
            irq_q   <= d_irq && tie_i;
            state_q <= d_last ? S_IDLE : S_FETCH;
          end
        end
        S_BURST: if (burst_ack_i) begin
          tadr_q  <= nxt_q;
          done_q  <= last_q;
          irq_q   <= irqp_q;
          state_q <= last_q ? S_IDLE : S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign tag_req_o    = (state_q == S_FETCH);
  assign tag_addr_o   = tadr_q;
  assign burst_req_o  = (state_q == S_BURST);
  assign burst_addr_o = madr_q;
  assign burst_qwc_o  = qwc_q;
  assign tag_hi_o     = hi_q;
  assign irq_o        = irq_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int AW  = 32,
  parameter int SPW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [AW-1:0]  start_tadr_i,
  input logic           tie_i,
  input logic           busy_o,
  input logic           tag_req_o,
  input logic [AW-1:0]  tag_addr_o,
  input logic           tag_vld_i,
  input logic [63:0]    tag_data_i,
  input logic           burst_req_o,
  input logic [AW-1:0]  burst_addr_o,
  input logic [15:0]    burst_qwc_o,
  input logic           burst_ack_i,
  input logic [15:0]    tag_hi_o,
  input logic [SPW-1:0] asp_o,
  input logic           irq_o,
  input logic           done_o,
  input logic           err_o
);
  a_r11_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r13_burst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_req_o && !burst_ack_i) |=>
      (burst_req_o && $stable(burst_addr_o) && $stable(burst_qwc_o)));
  a_r13_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tag_req_o && burst_req_o));
  a_r9_no_empty_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o |-> (burst_qwc_o != '0));
  a_r6_asp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asp_o <= SPW'(2));
  a_r8_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!busy_o && !done_o));
  a_r12_tag_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_req_o |-> (tag_addr_o[3:0] == 4'h0));
  a_r2_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && start_tadr_i[3:0] == 4'h0) |=> (busy_o && tag_req_o));
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(AW), .SPW(SPW)) u_chk (.*);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_tadr = '0;
  logic        tie = 1'b0;
  logic        busy, tag_req, burst_req, irq, done, err;
  logic [31:0] tag_addr, burst_addr;
  logic        tag_vld = 1'b0;
  logic [63:0] tag_data = '0;
  logic [15:0] burst_qwc, tag_hi;
  logic        burst_ack = 1'b0;
  logic [1:0]  asp;

  int total = 0, bad = 0;
  int done_cnt = 0, irq_cnt = 0, asp_max = 0, err_seen = 0;
  int tag_lat = 0, bst_lat = 0, tag_wait = 0, bst_wait = 0;
  bit finished = 0;
  logic [63:0] mem [int];
  logic [47:0] blog [$];

  always #(CLK_NS/2) clk = ~clk;

  dma_chain_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_tadr_i(start_tadr),
    .tie_i(tie), .busy_o(busy), .tag_req_o(tag_req), .tag_addr_o(tag_addr),
    .tag_vld_i(tag_vld), .tag_data_i(tag_data), .burst_req_o(burst_req),
    .burst_addr_o(burst_addr), .burst_qwc_o(burst_qwc), .burst_ack_i(burst_ack),
    .tag_hi_o(tag_hi), .asp_o(asp), .irq_o(irq), .done_o(done), .err_o(err)
  );

  // behavioural reference model
  int          ms;
  logic [31:0] mt, mm, mnx;
  int          mq;
  bit          mlast, mirqp, mdone, mirq, merr;
  logic [15:0] mhi;
  logic [31:0] mstk [$];

  function automatic void m_finish(logic [31:0] nx, bit last, bit ip);
    mdone = last; mirq = ip; ms = last ? 0 : 1; mt = nx;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mt = 0; mm = 0; mnx = 0; mq = 0; mlast = 0; mirqp = 0;
      mdone = 0; mirq = 0; merr = 0; mhi = 0; mstk.delete();
    end else begin
      mdone = 0; mirq = 0;
      if (ms == 0) begin
        if (start) begin
          if (start_tadr[3:0] != 0) merr = 1;
          else begin ms = 1; mt = start_tadr; merr = 0; mstk.delete(); end
        end
      end else if (ms == 1) begin
        if (tag_vld) begin
          logic [31:0] a, at, ap, pay, nx;
          int k, q; bit last, badt, usea;
          a = tag_data[63:32]; k = tag_data[30:28]; q = tag_data[15:0];
          mhi = tag_data[31:16];
          at = mt + 16; ap = at + q * 16;
          usea = (k == 0 || k == 2 || k == 3 || k == 4 || k == 5);
          badt = (usea && a[3:0] != 0) || (k == 5 && mstk.size() == 2);
          if (badt) begin merr = 1; ms = 0; end
          else begin
            pay = at; nx = ap; last = 0;
            case (k)
              0: begin pay = a; last = 1; end
              2: nx = a;
              3, 4: begin pay = a; nx = at; end
              5: begin nx = a; mstk.push_back(ap); end
              6: if (mstk.size() == 0) last = 1; else nx = mstk.pop_back();
              7: last = 1;
              default: ;
            endcase
            if (q != 0) begin
              ms = 2; mm = pay; mq = q; mnx = nx; mlast = last;
              mirqp = tag_data[31] && tie;
            end else m_finish(nx, last, tag_data[31] && tie);
          end
        end
      end else if (burst_ack) m_finish(mnx, mlast, mirqp);
    end
  end

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("R2 busy", busy, ms != 0);
    check("R2 tag_req", tag_req, ms == 1);
    if (ms == 1) check("R4 tag_addr", tag_addr, mt);
    check("R13 burst_req", burst_req, ms == 2);
    if (ms == 2) check("R13 burst", {burst_addr, burst_qwc}, {mm, 16'(mq)});
    check("R6 asp", asp, mstk.size());
    check("R11 done", done, mdone);
    check("R10 irq", irq, mirq);
    check("R8 err", err, merr);
    check("R3 tag_hi", tag_hi, mhi);
    if (done) done_cnt++;
    if (irq) irq_cnt++;
    if (err) err_seen = 1;
    if (int'(asp) > asp_max) asp_max = asp;
    tag_vld = 0; burst_ack = 0;
    if (tag_req) begin
      if (tag_wait >= tag_lat) begin
        tag_vld = 1; tag_wait = 0;
        tag_data = mem.exists(int'(tag_addr)) ? mem[int'(tag_addr)] : mk(7, 0, 0, 0);
      end else tag_wait++;
    end
    if (burst_req) begin
      if (bst_wait >= bst_lat) begin
        burst_ack = 1; bst_wait = 0; blog.push_back({burst_addr, burst_qwc});
      end else bst_wait++;
    end
  endtask

  function automatic logic [63:0] mk(int k, bit ir, logic [31:0] a, logic [15:0] q);
    return {a, ir, 3'(k), 2'b00, 10'b0, q};
  endfunction

  task automatic run(logic [31:0] at, int limit);
    done_cnt = 0; irq_cnt = 0; asp_max = 0; err_seen = 0; blog.delete();
    start_tadr = at; start = 1; tick(); start = 0;
    for (int i = 0; i < limit && busy; i++) tick();
    tick(); tick();
  endtask

  task automatic check_log(string req, logic [47:0] exp [$]);
    check(req, blog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < blog.size(); i++) check(req, blog[i], exp[i]);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0); check("R1 tag_req", tag_req, 0);
    check("R1 burst_req", burst_req, 0); check("R1 done", done, 0);
    check("R1 irq", irq, 0); check("R1 err", err, 0);
    check("R1 asp", asp, 0); check("R1 tag_hi", tag_hi, 0);
    rst_n = 1; tick();

    // R4 count then stop
    mem[32'h100] = mk(1, 0, 0, 2); mem[32'h130] = mk(7, 0, 0, 1);
    run(32'h100, 200);
    check_log("R4 bursts", '{{32'h110, 16'd2}, {32'h140, 16'd1}});
    check("R11 done once", done_cnt, 1);
    check("R3 tag_hi stop", tag_hi, 16'h7000);

    // R5 R9 jump, reference, zero-length, ref-stop
    mem[32'h200] = mk(2, 0, 32'h400, 1); mem[32'h400] = mk(3, 0, 32'h1000, 3);
    mem[32'h410] = mk(4, 0, 32'h2000, 0); mem[32'h420] = mk(0, 0, 32'h3000, 2);
    tag_lat = 1; bst_lat = 3;
    run(32'h200, 300);
    check_log("R5 R9 bursts", '{{32'h210, 16'd1}, {32'h1000, 16'd3}, {32'h3000, 16'd2}});
    check("R5 done", done_cnt, 1);

    // R6 R7 nested call / return
    mem[32'h500] = mk(5, 0, 32'h600, 1); mem[32'h600] = mk(5, 0, 32'h700, 0);
    mem[32'h700] = mk(6, 0, 0, 1); mem[32'h610] = mk(6, 0, 0, 0);
    mem[32'h520] = mk(6, 0, 0, 1);
    tag_lat = 0; bst_lat = 0;
    run(32'h500, 300);
    check_log("R7 bursts", '{{32'h510, 16'd1}, {32'h710, 16'd1}, {32'h530, 16'd1}});
    check("R6 asp peak", asp_max, 2);
    check("R7 asp end", asp, 0);
    check("R7 done", done_cnt, 1);

    // R8 third-level call
    mem[32'h800] = mk(5, 0, 32'h900, 0); mem[32'h900] = mk(5, 0, 32'hA00, 0);
    mem[32'hA00] = mk(5, 0, 32'hB00, 0);
    run(32'h800, 300);
    check("R8 err", err, 1); check("R8 busy", busy, 0);
    check("R8 no done", done_cnt, 0); check("R8 no burst", blog.size(), 0);

    // R10 interrupt enabled then disabled
    mem[32'hC00] = mk(1, 1, 0, 1); mem[32'hC20] = mk(7, 1, 0, 0);
    tie = 1; run(32'hC00, 200);
    check("R10 irq on", irq_cnt, 2);
    check("R2 err cleared", err, 0);
    check("R3 tag_hi irq", tag_hi, 16'hF000);
    tie = 0; run(32'hC00, 200);
    check("R10 irq off", irq_cnt, 0);

    // R12 misaligned tag address and start address
    mem[32'hD00] = mk(2, 0, 32'h1234, 1);
    run(32'hD00, 200);
    check("R12 err tag", err, 1); check("R12 no burst", blog.size(), 0);
    check("R12 no done", done_cnt, 0);
    run(32'h100, 200);
    run(32'hD08, 20);
    check("R12 err start", err, 1); check("R12 idle", busy, 0);

    // R2 R13 second start while busy, slow responders
    tag_lat = 2; bst_lat = 4;
    done_cnt = 0; blog.delete();
    start_tadr = 32'h100; start = 1; tick(); start = 0;
    for (int i = 0; i < 6; i++) tick();
    start_tadr = 32'h200; start = 1; tick(); start = 0;
    for (int i = 0; i < 300 && busy; i++) tick();
    tick();
    check_log("R2 ignore start", '{{32'h110, 16'd2}, {32'h140, 16'd1}});
    check("R2 done", done_cnt, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule